// File: doc/BRIEF.md
# Radio Packet Header Framer

This block turns a stream of 64-bit payload words into outgoing radio transport packets. For each packet a producer first hands over one metadata record: a requested packet kind, an optional 64-bit timestamp, and a 32-bit stream identifier. It then sends the payload words and marks the final one with a byte-valid count. The block keeps a 12-bit sequence counter and stores the whole payload before it sends anything. Once the payload is complete it knows the total byte length, so it emits a single 64-bit header line, then the timestamp line if one was requested, then the stored payload.

The output uses valid/ready flow control, and `out_last` marks the last beat of every packet. A payload that does not fit in the internal store, or that would make the length field overflow, is discarded in full. In that case `ovf` pulses for one cycle and the sequence counter does not change. The block accepts no new metadata until the current packet has left or has been dropped.

Top module: `pkt_framer`

## Requirements
- R1: The first output beat of a packet is the header: bits 63:62 and 60 carry the kind code, bit 61 is 1 when a timestamp follows, bits 59:48 carry the sequence number, bits 47:32 carry the total byte length, and bits 31:0 carry the stream identifier.
- R2: `meta_kind` values 0 through 5 (data, data end-of-burst, flow control, command, command response, command response error) place {bit63, bit62, bit60} = 000, 001, 010, 100, 110, 111 respectively; values 6 and 7 are sent as data (000).
- R3: When `meta_ts_en` is 1, the second beat is `meta_ts` and the payload starts on the third beat; otherwise the payload starts on the second beat.
- R4: The length field equals 8 + 8 (if a timestamp is present) + 8 × (payload words − 1) + the final word's byte count. A byte count of 1 to 8 is taken as given, and 0 or 9 to 15 count as 8.
- R5: The sequence counter is 0 after reset and advances by one after the final beat of each packet is accepted, wrapping from 4095 to 0.
- R6: Payload words leave in arrival order, and `out_last` is 1 on the final beat of the packet only.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R8: A payload of more than DEPTH (default 256) words, or one whose length would exceed 65535, produces no output beats and raises `ovf` for exactly one cycle after its last word. The next packet uses the same sequence number.
- R9: `meta_ready` is 0 from the acceptance of metadata until the packet's final beat is accepted or the packet is dropped. `pl_ready` is 1 only while payload is being collected.
- R10: After a synchronous reset, `meta_ready` is 1 and `pl_ready`, `out_valid` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meta_valid | input | 1 | Metadata record offered |
| meta_ready | output | 1 | Metadata record accepted this cycle if valid |
| meta_kind | input | 3 | Requested packet kind code (see R2) |
| meta_ts_en | input | 1 | Send a timestamp line |
| meta_ts | input | 64 | Timestamp value |
| meta_sid | input | 32 | Stream identifier |
| pl_valid | input | 1 | Payload word offered |
| pl_ready | output | 1 | Payload word accepted this cycle if valid |
| pl_data | input | 64 | Payload word |
| pl_last | input | 1 | Marks the final payload word |
| pl_bytes | input | 4 | Valid bytes in the final word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 64 | Output line |
| out_last | output | 1 | Final beat of the packet |
| ovf | output | 1 | One-cycle pulse when a packet is dropped |

## Verification
The bound checker watches properties that must hold on every cycle: the output stays unchanged under back-pressure, `out_last` never appears without `out_valid`, the metadata port stays closed while payload is collected or a packet is being sent, the sequence counter changes only on a final-beat handshake and then by exactly one, and a drop pulse comes with no output and an unchanged counter. The header bit layout, the kind-to-bit mapping, the length sums with and without a timestamp, clamping of the final byte count, word ordering, the exact-capacity and one-over-capacity boundaries, and the 4095-to-0 wrap all depend on what was offered. Only the bench scenarios can show these, by comparing each beat with values the bench computes.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    localparam int LINE_W = 64;
    localparam int SEQ_W  = 12;
    localparam int LEN_W  = 16;
    localparam int SID_W  = 32;
    localparam int KIND_W = 3;
    localparam int BC_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_HDR  = 3'd2,
        ST_TS   = 3'd3,
        ST_BODY = 3'd4
    } fr_state_e;

    // returns {bit63, bit62, bit60}
    function automatic logic [2:0] kind_bits(input logic [KIND_W-1:0] k);
        case (k)
            3'd1:    kind_bits = 3'b001;
            3'd2:    kind_bits = 3'b010;
            3'd3:    kind_bits = 3'b100;
            3'd4:    kind_bits = 3'b110;
            3'd5:    kind_bits = 3'b111;
            default: kind_bits = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pfr_buf.sv
module pfr_buf #(
    parameter int DEPTH = 256,
    parameter int W     = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pfr_len_calc.sv
module pfr_len_calc import pfr_pkg::*; #(
    parameter int CW = 9
) (
    input  logic [CW-1:0]    nwords,
    input  logic [BC_W-1:0]  last_bytes,
    input  logic             ts_en,
    output logic [LEN_W-1:0] len,
    output logic             too_long
);

    logic [31:0] lb_eff;
    logic [31:0] sum;

    always_comb begin
        if (last_bytes == '0 || last_bytes > BC_W'(8)) begin
            lb_eff = 32'd8;
        end else begin
            lb_eff = 32'(last_bytes);
        end
        sum = 32'd8 + (ts_en ? 32'd8 : 32'd0)
            + ((32'(nwords) - 32'd1) << 3) + lb_eff;
        len      = sum[LEN_W-1:0];
        too_long = (sum > 32'((1 << LEN_W) - 1));
    end

endmodule

// File: rtl/pfr_hdr_enc.sv
module pfr_hdr_enc import pfr_pkg::*; (
    input  logic [KIND_W-1:0] kind,
    input  logic              ts_en,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [LEN_W-1:0]  len,
    input  logic [SID_W-1:0]  sid,
    output logic [LINE_W-1:0] hdr
);

    logic [2:0] kb;

    always_comb begin
        kb  = kind_bits(kind);
        hdr = {kb[2], kb[1], ts_en, kb[0], seq, len, sid};
    end

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer import pfr_pkg::*; #(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meta_valid,
    output logic              meta_ready,
    input  logic [2:0]        meta_kind,
    input  logic              meta_ts_en,
    input  logic [63:0]       meta_ts,
    input  logic [31:0]       meta_sid,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [63:0]       pl_data,
    input  logic              pl_last,
    input  logic [3:0]        pl_bytes,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_data,
    output logic              out_last,
    output logic              ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        fr_state_e          st;
        logic [KIND_W-1:0]  kind;
        logic               ts_en;
        logic [LINE_W-1:0]  ts;
        logic [SID_W-1:0]   sid;
        logic [SEQ_W-1:0]   seq;
        logic [CW-1:0]      wcnt;
        logic [AW-1:0]      rcnt;
        logic [LEN_W-1:0]   len;
        logic               drop;
        logic               ovf;
    } fr_regs_t;

    fr_regs_t r_q, r_d;

    logic              wr_en;
    logic [LINE_W-1:0] rd_word;
    logic [LEN_W-1:0]  calc_len;
    logic              calc_too_long;
    logic [LINE_W-1:0] hdr_line;
    logic              body_last;
    logic [SEQ_W-1:0]  seq_cur;

    pfr_buf #(.DEPTH(DEPTH), .W(LINE_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (r_q.wcnt[AW-1:0]),
        .wr_data (pl_data),
        .rd_addr (r_q.rcnt),
        .rd_data (rd_word)
    );

    pfr_len_calc #(.CW(CW)) u_len (
        .nwords     (r_q.wcnt + CW'(1)),
        .last_bytes (pl_bytes),
        .ts_en      (r_q.ts_en),
        .len        (calc_len),
        .too_long   (calc_too_long)
    );

    pfr_hdr_enc u_hdr (
        .kind  (r_q.kind),
        .ts_en (r_q.ts_en),
        .seq   (r_q.seq),
        .len   (r_q.len),
        .sid   (r_q.sid),
        .hdr   (hdr_line)
    );

    assign body_last = (CW'(r_q.rcnt) == r_q.wcnt - CW'(1));
    assign seq_cur   = r_q.seq;

    always_comb begin
        r_d     = r_q;
        r_d.ovf = 1'b0;
        wr_en   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (meta_valid) begin
                    r_d.kind  = meta_kind;
                    r_d.ts_en = meta_ts_en;
                    r_d.ts    = meta_ts;
                    r_d.sid   = meta_sid;
                    r_d.wcnt  = '0;
                    r_d.drop  = 1'b0;
                    r_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (pl_valid) begin
                    if (r_q.drop || r_q.wcnt == CW'(DEPTH)) begin
                        r_d.drop = 1'b1;
                    end else begin
                        wr_en    = 1'b1;
                        r_d.wcnt = r_q.wcnt + CW'(1);
                    end
                    if (pl_last) begin
                        if (r_d.drop || calc_too_long) begin
                            r_d.ovf = 1'b1;
                            r_d.st  = ST_IDLE;
                        end else begin
                            r_d.len  = calc_len;
                            r_d.rcnt = '0;
                            r_d.st   = ST_HDR;
                        end
                    end
                end
            end
            ST_HDR: begin
                if (out_ready) begin
                    r_d.st = r_q.ts_en ? ST_TS : ST_BODY;
                end
            end
            ST_TS: begin
                if (out_ready) begin
                    r_d.st = ST_BODY;
                end
            end
            ST_BODY: begin
                if (out_ready) begin
                    if (body_last) begin
                        r_d.seq = r_q.seq + SEQ_W'(1);
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.rcnt = r_q.rcnt + AW'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        meta_ready = (r_q.st == ST_IDLE);
        pl_ready   = (r_q.st == ST_FILL);
        out_valid  = (r_q.st == ST_HDR) || (r_q.st == ST_TS) || (r_q.st == ST_BODY);
        out_last   = (r_q.st == ST_BODY) && body_last;
        ovf        = r_q.ovf;
        case (r_q.st)
            ST_HDR:  out_data = hdr_line;
            ST_TS:   out_data = r_q.ts;
            ST_BODY: out_data = rd_word;
            default: out_data = '0;
        endcase
    end

endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
    input logic        clk,
    input logic        rst,
    input logic        meta_ready,
    input logic        pl_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_last,
    input logic        ovf,
    input logic [11:0] seq
);

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R9
    meta_closed_chk: assert property (@(posedge clk) disable iff (rst)
        meta_ready |-> (!pl_ready && !out_valid));

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (seq == $past(seq) + 12'd1));

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready && out_last) |=> $stable(seq));

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (!out_valid && $stable(seq)));

endmodule

bind pkt_framer pkt_framer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .meta_ready (meta_ready),
    .pl_ready   (pl_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .ovf        (ovf),
    .seq        (seq_cur)
);

// File: tb/pkt_framer_test.sv
module pkt_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meta_valid = 1'b0;
    logic        meta_ready;
    logic [2:0]  meta_kind = '0;
    logic        meta_ts_en = 1'b0;
    logic [63:0] meta_ts = '0;
    logic [31:0] meta_sid = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [63:0] pl_data = '0;
    logic        pl_last = 1'b0;
    logic [3:0]  pl_bytes = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        out_last;
    logic        ovf;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] exp_seq = '0;
    logic [63:0] pay [0:299];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_framer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_kind(meta_kind),
        .meta_ts_en(meta_ts_en), .meta_ts(meta_ts), .meta_sid(meta_sid),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_last(pl_last), .pl_bytes(pl_bytes),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_kind(input int k);
        case (k)
            1: return 3'b001;
            2: return 3'b010;
            3: return 3'b100;
            4: return 3'b110;
            5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [63:0] exp_hdr(input int k, input bit hts, input logic [11:0] sq,
                                            input logic [15:0] ln, input logic [31:0] sid);
        logic [2:0] kb;
        kb = exp_kind(k);
        return {kb[2], kb[1], hts, kb[0], sq, ln, sid};
    endfunction

    // Called at a negedge; returns at a negedge with the block idle.
    task automatic send_pkt(input int kind, input bit hts, input int nw, input int lb,
                            input int rdy, input bit drop, input string tag);
        logic [63:0] ts;
        logic [31:0] sid;
        logic [63:0] hdr, held, expw;
        int clb, elen, total, beat;
        bit stalled;
        ts  = {$urandom, $urandom};
        sid = $urandom;
        for (int i = 0; i < nw && i < 300; i++) pay[i] = {$urandom, $urandom};
        clb  = (lb < 1 || lb > 8) ? 8 : lb;
        elen = 8 + (hts ? 8 : 0) + 8 * (nw - 1) + clb;
        hdr  = exp_hdr(kind, hts, exp_seq, elen[15:0], sid);
        meta_valid = 1'b1; meta_kind = 3'(kind); meta_ts_en = hts; meta_ts = ts; meta_sid = sid;
        while (!meta_ready) @(negedge clk);
        @(negedge clk);
        meta_valid = 1'b0;
        for (int i = 0; i < nw; i++) begin
            pl_valid = 1'b1; pl_data = pay[i]; pl_last = (i == nw - 1); pl_bytes = 4'(lb);
            while (!pl_ready) @(negedge clk);
            if (i == 0) chk(!meta_ready, "R9 meta_ready while filling", 64'(meta_ready), 64'd0);
            @(negedge clk);
        end
        pl_valid = 1'b0; pl_last = 1'b0;
        if (drop) begin
            chk(ovf && !out_valid, "R8 drop pulse", {62'd0, ovf, out_valid}, 64'd2);
            @(negedge clk);
            chk(!ovf && !out_valid, "R8 single-cycle pulse", {62'd0, ovf, out_valid}, 64'd0);
            return;
        end
        total = 1 + (hts ? 1 : 0) + nw;
        beat = 0; stalled = 0; held = '0;
        while (beat < total) begin
            if (stalled)
                chk(out_valid && out_data == held, "R7 hold under back-pressure", out_data, held);
            out_ready = (($urandom % 100) < rdy);
            if (beat == 0) expw = hdr;
            else if (hts && beat == 1) expw = ts;
            else expw = pay[beat - 1 - (hts ? 1 : 0)];
            stalled = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                if (beat == 0) chk(!meta_ready, "R9 meta_ready while sending", 64'(meta_ready), 64'd0);
                chk(out_data == expw, (beat == 0) ? tag : ((hts && beat == 1) ? "R3 timestamp line" : "R6 payload order"),
                    out_data, expw);
                chk(out_last == (beat == total - 1), "R6 last flag", 64'(out_last), 64'(beat == total - 1));
                beat++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        exp_seq = exp_seq + 12'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1701));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(meta_ready && !pl_ready && !out_valid && !ovf, "R10 reset outputs",
            {60'd0, meta_ready, pl_ready, out_valid, ovf}, 64'h8);
        // R2 every kind code, R1 layout, R5 starting at 0
        for (int k = 0; k < 8; k++) send_pkt(k, 0, 1, 8, 100, 0, "R2 kind header");
        // R3 timestamp with back-pressure
        send_pkt(4, 1, 3, 5, 50, 0, "R3 header with ts");
        send_pkt(0, 1, 1, 1, 30, 0, "R3 short ts packet");
        // R4 byte-count clamping
        send_pkt(1, 0, 2, 0, 70, 0, "R4 count 0 as 8");
        send_pkt(2, 1, 2, 9, 70, 0, "R4 count 9 as 8");
        send_pkt(3, 0, 4, 3, 70, 0, "R4 partial last word");
        // R4 exact capacity, R8 one over capacity then unchanged sequence
        send_pkt(0, 1, DEPTH, 8, 90, 0, "R4 full buffer");
        send_pkt(0, 0, DEPTH + 1, 8, 90, 1, "R8");
        send_pkt(5, 0, 1, 2, 100, 0, "R8 sequence unchanged after drop");
        // R1 R6 R7 random mix
        for (int p = 0; p < 40; p++)
            send_pkt(int'($urandom % 8), bit'($urandom % 2), 1 + int'($urandom % 20),
                     int'($urandom % 16), 30 + int'($urandom % 70), 0, "R1 random header");
        // R5 wrap from 4095 to 0
        for (int p = 0; p < 4100; p++) send_pkt(p % 6, 0, 1, 8, 100, 0, "R5 sequence");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule